// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a calendar as a set of BCD fields: seconds, minutes, 24-hour hours, day of week, day of month, month, a two-digit year and a century flag. An external one-pulse-per-second tick advances the seconds field. Each wrap is passed to the next field by a small carry-ripple state machine, one field per clock cycle. The block works out the length of each month, including February in leap years, from the current month and year. The leap test is a divisible-by-four check on the two-digit year.

A host loads and reads the fields through seven byte-wide registers at addresses 0 to 6. A halt bit kept with the seconds register freezes the counting chain. A century enable bit and a century flag are packed into the hours register. When the year rolls over from 99 to 00, the flag toggles only if the enable bit is set.

The carry-ripple machine has seven states. In S_IDLE it waits for a tick. A tick moves it to S_SEC when the halt bit is clear and no host write is present. In each of S_SEC, S_MIN, S_HOUR, S_DAY (day of month together with day of week) and S_MON it increments its field. It then moves to the next state if that field wrapped, and returns to S_IDLE if it did not. S_YEAR increments the year, updates the century flag and always returns to S_IDLE. A host write in any state sends the machine to S_IDLE without incrementing anything in that cycle.

Top module: `rtc_time_chain`

## Requirements
- R1: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count 00 to 59 in BCD. Going from 59 to 00 carries into the next field.
- R2: Hours (address 2, bits 5:0) count 00 to 23 in BCD. Going from 23 to 00 advances both the day of month and the day of week.
- R3: Day of week (address 3, bits 2:0) counts 1 to 7 and then returns to 1.
- R4: Day of month (address 4, bits 5:0, BCD) returns from 31 to 01 in months 01, 03, 05, 07, 08, 10 and 12, and from 30 to 01 in months 04, 06, 09 and 11. That return carries into the month.
- R5: In February the day of month returns to 01 after 29 when the BCD year is divisible by 4 (00 included), and after 28 otherwise.
- R6: Month (address 5, bits 4:0) runs 01 to 12, and the step from 12 to 01 carries into the year. Year (address 6, bits 7:0) runs 00 to 99 and wraps to 00.
- R7: Address 2 bit 7 is the century enable and bit 6 is the century flag. When the year wraps from 99 to 00 with the enable set, the flag toggles. With the enable clear, the flag holds its value.
- R8: Address 0 bit 7 is the halt bit. While it is 1, ticks change no field.
- R9: Any host write takes priority over counting. A tick that arrives in the same cycle as a write is dropped, and a write during a carry ripple ends the ripple.
- R10: Unused register bits read as 0. Address 7 reads as 0, and writes to it change no field.
- R11: After reset: halt bit 0, century enable 1, century flag 1, time 00:00:00, day of week 1, date 01, month 01, year 00.
- R12: A tick sampled at one clock edge updates seconds at the second edge after it. Each carry updates the next field one edge later, so a full ripple from seconds to year finishes within seven edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | AW (3) | Host write register address |
| wr_data_i | input | DW (8) | Host write data |
| rd_addr_i | input | AW (3) | Host read register address |
| rd_data_o | output | DW (8) | Register contents at rd_addr_i, combinational |

## Verification
Several behaviours are checked on every cycle. A seconds increment at 59 must give 00, and a day-of-week step from 7 must give 1. The carry machine never issues more than one field increment at a time, and it issues none in a cycle with a host write. A seconds write always lands. The halt bit keeps seconds stable, and the century flag stays stable while its enable is clear. Month lengths, the BCD leap test on years such as 10 and 12, the full ripple from 23:59:59 on 31 December 99 into a new century, and the exact cycle on which each carry appears can only be shown by the bench's scenarios. Each of these depends on a particular preloaded calendar state.

// File: rtl/rtc_chain_pkg.sv
package rtc_chain_pkg;

    // carry-ripple states, one per field step
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_SEC  = 3'd1,
        S_MIN  = 3'd2,
        S_HOUR = 3'd3,
        S_DAY  = 3'd4,
        S_MON  = 3'd5,
        S_YEAR = 3'd6
    } ripple_e;

    // field steps in ripple order
    localparam int unsigned N_STEP    = 6;
    localparam int unsigned STEP_SEC  = 0;
    localparam int unsigned STEP_MIN  = 1;
    localparam int unsigned STEP_HOUR = 2;
    localparam int unsigned STEP_DATE = 3;
    localparam int unsigned STEP_MON  = 4;
    localparam int unsigned STEP_YEAR = 5;

    // stored field widths
    localparam int unsigned SEC_W  = 7;
    localparam int unsigned MIN_W  = 7;
    localparam int unsigned HR_W   = 6;
    localparam int unsigned DOW_W  = 3;
    localparam int unsigned DATE_W = 6;
    localparam int unsigned MON_W  = 5;
    localparam int unsigned YR_W   = 8;

    // register addresses
    localparam int unsigned ADR_SEC  = 0;
    localparam int unsigned ADR_MIN  = 1;
    localparam int unsigned ADR_HR   = 2;
    localparam int unsigned ADR_DOW  = 3;
    localparam int unsigned ADR_DATE = 4;
    localparam int unsigned ADR_MON  = 5;
    localparam int unsigned ADR_YR   = 6;

    // Leap test on a BCD year: (10*T + U) mod 4 equals (2*T + U) mod 4
    function automatic logic bcd_year_leap(input logic [7:0] yr);
        logic [4:0] s;
        s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
    parameter int          DW    = 8,
    parameter int unsigned FIRST = 0
) (
    input  logic [DW-1:0] cur_i,
    input  logic [DW-1:0] last_i,
    output logic [DW-1:0] nxt_o,
    output logic          wrap_o
);

    localparam int LO_W = 4;
    localparam int HI_W = DW - LO_W;

    logic [LO_W-1:0] lo;
    logic [HI_W-1:0] hi;

    assign lo = cur_i[LO_W-1:0];
    assign hi = cur_i[DW-1:LO_W];

    always_comb begin
        // BCD compare is monotonic for legal codes; >= also recovers from overrange loads
        wrap_o = (cur_i >= last_i);
        if (wrap_o) begin
            nxt_o = DW'(FIRST);
        end else if (lo >= LO_W'(9)) begin
            nxt_o = {hi + HI_W'(1), LO_W'(0)};
        end else begin
            nxt_o = {hi, lo + LO_W'(1)};
        end
    end

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_chain_pkg::*;
(
    input  logic [MON_W-1:0] mon_i,
    input  logic [YR_W-1:0]  yr_i,
    output logic [7:0]       last_day_o
);

    logic leap;

    assign leap = bcd_year_leap(yr_i);

    always_comb begin
        unique case (mon_i)
            5'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day_o = 8'h30;
            default:                    last_day_o = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_ripple_fsm.sv
module rtc_ripple_fsm
    import rtc_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              halt_i,
    input  logic              host_wr_i,
    input  logic [N_STEP-1:0] wrap_i,
    output logic [N_STEP-1:0] step_o
);

    ripple_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE: state_d = (tick_i && !halt_i && !host_wr_i) ? S_SEC : S_IDLE;
            S_SEC:  state_d = (!host_wr_i && wrap_i[STEP_SEC])  ? S_MIN  : S_IDLE;
            S_MIN:  state_d = (!host_wr_i && wrap_i[STEP_MIN])  ? S_HOUR : S_IDLE;
            S_HOUR: state_d = (!host_wr_i && wrap_i[STEP_HOUR]) ? S_DAY  : S_IDLE;
            S_DAY:  state_d = (!host_wr_i && wrap_i[STEP_DATE]) ? S_MON  : S_IDLE;
            S_MON:  state_d = (!host_wr_i && wrap_i[STEP_MON])  ? S_YEAR : S_IDLE;
            S_YEAR: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: one field increment per active state, suppressed by a host write
    always_comb begin
        step_o = '0;
        unique case (state_q)
            S_IDLE: step_o = '0;
            S_SEC:  step_o[STEP_SEC]  = !host_wr_i;
            S_MIN:  step_o[STEP_MIN]  = !host_wr_i;
            S_HOUR: step_o[STEP_HOUR] = !host_wr_i;
            S_DAY:  step_o[STEP_DATE] = !host_wr_i;
            S_MON:  step_o[STEP_MON]  = !host_wr_i;
            S_YEAR: step_o[STEP_YEAR] = !host_wr_i;
            default: step_o = '0;
        endcase
    end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_chain_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);

    localparam logic [AW-1:0] A_SEC  = AW'(ADR_SEC);
    localparam logic [AW-1:0] A_MIN  = AW'(ADR_MIN);
    localparam logic [AW-1:0] A_HR   = AW'(ADR_HR);
    localparam logic [AW-1:0] A_DOW  = AW'(ADR_DOW);
    localparam logic [AW-1:0] A_DATE = AW'(ADR_DATE);
    localparam logic [AW-1:0] A_MON  = AW'(ADR_MON);
    localparam logic [AW-1:0] A_YR   = AW'(ADR_YR);
    localparam logic [DOW_W-1:0] DOW_FIRST = DOW_W'(1);
    localparam logic [DOW_W-1:0] DOW_LAST  = DOW_W'(7);

    // field state
    logic              st_q;
    logic              ceb_q;
    logic              cb_q;
    logic [SEC_W-1:0]  sec_q;
    logic [MIN_W-1:0]  min_q;
    logic [HR_W-1:0]   hr_q;
    logic [DOW_W-1:0]  dow_q;
    logic [DATE_W-1:0] date_q;
    logic [MON_W-1:0]  mon_q;
    logic [YR_W-1:0]   yr_q;

    logic [DW-1:0]     cur_v  [N_STEP];
    logic [DW-1:0]     last_v [N_STEP];
    logic [DW-1:0]     nxt_v  [N_STEP];
    logic [N_STEP-1:0] wrap_v;
    logic [N_STEP-1:0] step_en;
    logic [7:0]        month_last;
    logic [DOW_W-1:0]  dow_nxt;

    rtc_month_len u_mlen (
        .mon_i      (mon_q),
        .yr_i       (yr_q),
        .last_day_o (month_last)
    );

    always_comb begin
        cur_v[STEP_SEC]   = DW'(sec_q);
        cur_v[STEP_MIN]   = DW'(min_q);
        cur_v[STEP_HOUR]  = DW'(hr_q);
        cur_v[STEP_DATE]  = DW'(date_q);
        cur_v[STEP_MON]   = DW'(mon_q);
        cur_v[STEP_YEAR]  = DW'(yr_q);
        last_v[STEP_SEC]  = DW'(8'h59);
        last_v[STEP_MIN]  = DW'(8'h59);
        last_v[STEP_HOUR] = DW'(8'h23);
        last_v[STEP_DATE] = DW'(month_last);
        last_v[STEP_MON]  = DW'(8'h12);
        last_v[STEP_YEAR] = DW'(8'h99);
    end

    // one BCD stepper per counting field; date and month start at 01
    for (genvar g = 0; g < N_STEP; g++) begin : g_field
        localparam int unsigned FIRST = (g == STEP_DATE || g == STEP_MON) ? 1 : 0;
        rtc_bcd_step #(
            .DW    (DW),
            .FIRST (FIRST)
        ) u_step (
            .cur_i  (cur_v[g]),
            .last_i (last_v[g]),
            .nxt_o  (nxt_v[g]),
            .wrap_o (wrap_v[g])
        );
    end

    assign dow_nxt = (dow_q >= DOW_LAST) ? DOW_FIRST : dow_q + DOW_W'(1);

    rtc_ripple_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .halt_i    (st_q),
        .host_wr_i (wr_en_i),
        .wrap_i    (wrap_v),
        .step_o    (step_en)
    );

    // field registers: host write first, counting otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= 1'b0;
            ceb_q  <= 1'b1;
            cb_q   <= 1'b1;
            sec_q  <= '0;
            min_q  <= '0;
            hr_q   <= '0;
            dow_q  <= DOW_FIRST;
            date_q <= DATE_W'(1);
            mon_q  <= MON_W'(1);
            yr_q   <= '0;
        end else if (wr_en_i) begin
            unique case (wr_addr_i)
                A_SEC: begin
                    st_q  <= wr_data_i[7];
                    sec_q <= wr_data_i[SEC_W-1:0];
                end
                A_MIN:  min_q <= wr_data_i[MIN_W-1:0];
                A_HR: begin
                    ceb_q <= wr_data_i[7];
                    cb_q  <= wr_data_i[6];
                    hr_q  <= wr_data_i[HR_W-1:0];
                end
                A_DOW:  dow_q  <= wr_data_i[DOW_W-1:0];
                A_DATE: date_q <= wr_data_i[DATE_W-1:0];
                A_MON:  mon_q  <= wr_data_i[MON_W-1:0];
                A_YR:   yr_q   <= wr_data_i[YR_W-1:0];
                default: ;
            endcase
        end else begin
            if (step_en[STEP_SEC])  sec_q <= nxt_v[STEP_SEC][SEC_W-1:0];
            if (step_en[STEP_MIN])  min_q <= nxt_v[STEP_MIN][MIN_W-1:0];
            if (step_en[STEP_HOUR]) hr_q  <= nxt_v[STEP_HOUR][HR_W-1:0];
            if (step_en[STEP_DATE]) begin
                date_q <= nxt_v[STEP_DATE][DATE_W-1:0];
                dow_q  <= dow_nxt;
            end
            if (step_en[STEP_MON])  mon_q <= nxt_v[STEP_MON][MON_W-1:0];
            if (step_en[STEP_YEAR]) begin
                yr_q <= nxt_v[STEP_YEAR][YR_W-1:0];
                if (ceb_q && wrap_v[STEP_YEAR]) begin
                    cb_q <= ~cb_q;
                end
            end
        end
    end

    // register view, unused bits zero
    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_SEC:  rd_data_o = DW'({st_q, sec_q});
            A_MIN:  rd_data_o = DW'(min_q);
            A_HR:   rd_data_o = DW'({ceb_q, cb_q, hr_q});
            A_DOW:  rd_data_o = DW'(dow_q);
            A_DATE: rd_data_o = DW'(date_q);
            A_MON:  rd_data_o = DW'(mon_q);
            A_YR:   rd_data_o = DW'(yr_q);
            default: rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/rtc_time_chain_chk.sv
module rtc_time_chain_chk #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en_i,
    input logic [AW-1:0] wr_addr_i,
    input logic [DW-1:0] wr_data_i,
    input logic          st_q,
    input logic          ceb_q,
    input logic          cb_q,
    input logic [6:0]    sec_q,
    input logic [2:0]    dow_q,
    input logic [5:0]    step_en
);

    // R1: a seconds increment from 59 lands on 00
    p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en[0] && sec_q == 7'h59) |=> (sec_q == 7'h00));

    // R3: day of week steps from 7 back to 1
    p_dow_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en[3] && dow_q == 3'd7) |=> (dow_q == 3'd1));

    // R7: century flag holds while its enable is clear and no hours write
    p_century_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ceb_q && !(wr_en_i && wr_addr_i == AW'(2))) |=> $stable(cb_q));

    // R8: halted chain leaves seconds unchanged without a write
    p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q && !wr_en_i) |=> $stable(sec_q));

    // R9: a seconds write always lands, whatever the ripple is doing
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == AW'(0)) |=> (sec_q == $past(wr_data_i[6:0])));

    // R9: no field increment in a cycle with a host write
    p_write_no_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (step_en == 6'b0));

    // R12: the ripple advances one field at a time
    p_one_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_en));

endmodule

bind rtc_time_chain rtc_time_chain_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .st_q      (st_q),
    .ceb_q     (ceb_q),
    .cb_q      (cb_q),
    .sec_q     (sec_q),
    .dow_q     (dow_q),
    .step_en   (step_en)
);

// File: tb/rtc_time_chain_tb.sv
module rtc_time_chain_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;

    // vectors {year, month, date, dow, hours byte, minutes, seconds}
    localparam logic [55:0] VIN [NV] = '{
        56'h24_05_15_03_D2_34_56, 56'h24_05_15_03_D2_10_59, 56'h24_05_15_03_C8_59_59,
        56'h24_05_15_03_C9_59_59, 56'h24_05_15_07_E3_59_59, 56'h24_04_30_02_E3_59_59,
        56'h23_01_31_02_E3_59_59, 56'h23_01_30_02_E3_59_59, 56'h24_09_30_01_E3_59_59,
        56'h24_11_30_01_E3_59_59, 56'h23_02_28_04_E3_59_59, 56'h24_02_28_04_E3_59_59,
        56'h24_02_29_04_E3_59_59, 56'h00_02_28_04_E3_59_59, 56'h10_02_28_04_E3_59_59,
        56'h12_02_28_04_E3_59_59, 56'h24_12_31_06_E3_59_59, 56'h99_12_31_06_E3_59_59,
        56'h99_12_31_06_A3_59_59, 56'h99_12_31_06_63_59_59, 56'h24_05_15_03_D2_58_59
    };
    localparam logic [55:0] VOUT [NV] = '{
        56'h24_05_15_03_D2_34_57, 56'h24_05_15_03_D2_11_00, 56'h24_05_15_03_C9_00_00,
        56'h24_05_15_03_D0_00_00, 56'h24_05_16_01_C0_00_00, 56'h24_05_01_03_C0_00_00,
        56'h23_02_01_03_C0_00_00, 56'h23_01_31_03_C0_00_00, 56'h24_10_01_02_C0_00_00,
        56'h24_12_01_02_C0_00_00, 56'h23_03_01_05_C0_00_00, 56'h24_02_29_05_C0_00_00,
        56'h24_03_01_05_C0_00_00, 56'h00_02_29_05_C0_00_00, 56'h10_03_01_05_C0_00_00,
        56'h12_02_29_05_C0_00_00, 56'h25_01_01_07_C0_00_00, 56'h00_01_01_07_80_00_00,
        56'h00_01_01_07_C0_00_00, 56'h00_01_01_07_40_00_00, 56'h24_05_15_03_D2_59_00
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_time_chain u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    function automatic string vec_req(input int i);
        if (i <= 1) return "R1";
        if (i <= 3) return "R2";
        if (i == 4) return "R3";
        if (i <= 9) return "R4";
        if (i <= 15) return "R5";
        if (i == 16) return "R6";
        if (i <= 19) return "R7";
        return "R1";
    endfunction

    task automatic check(input string req, input logic [55:0] act, input logic [55:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic load_all(input logic [55:0] v);
        for (int i = 0; i < 7; i++) wr_reg(3'(i), v[8*i +: 8]);
    endtask

    task automatic read_all(output logic [55:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < 7; i++) begin
            rd_reg(3'(i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [55:0] got;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        read_all(got);
        check("R11", got, 56'h00_01_01_01_C0_00_00);

        // table walk: preload, one tick, full ripple, compare
        for (int i = 0; i < NV; i++) begin
            load_all(VIN[i]);
            pulse_tick();
            wait_cycles(10);
            read_all(got);
            check(vec_req(i), got, VOUT[i]);
        end

        // R10: unused bits read 0, address 7 reads 0 and is ignored
        load_all(56'h24_05_15_03_D2_34_56);
        wr_reg(3'd1, 8'hFF); wr_reg(3'd3, 8'hFF); wr_reg(3'd4, 8'hFF); wr_reg(3'd5, 8'hFF);
        rd_reg(3'd1, b); check("R10", 56'(b), 56'h7F);
        rd_reg(3'd3, b); check("R10", 56'(b), 56'h07);
        rd_reg(3'd4, b); check("R10", 56'(b), 56'h3F);
        rd_reg(3'd5, b); check("R10", 56'(b), 56'h1F);
        load_all(56'h24_05_15_03_D2_34_56);
        wr_reg(3'd7, 8'hFF);
        rd_reg(3'd7, b); check("R10", 56'(b), 56'h00);
        read_all(got); check("R10", got, 56'h24_05_15_03_D2_34_56);

        // R8: halt bit freezes the chain
        wr_reg(3'd0, 8'hB0);
        pulse_tick(); wait_cycles(10);
        read_all(got); check("R8", got, 56'h24_05_15_03_D2_34_B0);
        wr_reg(3'd0, 8'h30);
        pulse_tick(); wait_cycles(10);
        rd_reg(3'd0, b); check("R8", 56'(b), 56'h31);

        // R9: tick in a write cycle is dropped, the write lands
        wr_reg(3'd0, 8'h10);
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd1; wr_data_i = 8'h21;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        wait_cycles(10);
        read_all(got); check("R9", got, 56'h24_05_15_03_D2_21_10);

        // R9: write during a ripple ends it (seconds update, minutes stay)
        load_all(56'h24_05_15_03_D2_20_59);
        pulse_tick();               // edge E1 sampled the tick
        @(negedge clk);             // E2: seconds stepped
        wr_en_i = 1'b1; wr_addr_i = 3'd5; wr_data_i = 8'h05;
        @(negedge clk);             // E3: write instead of minute step
        wr_en_i = 1'b0;
        wait_cycles(8);
        read_all(got); check("R9", got, 56'h24_05_15_03_D2_20_00);

        // R12: ripple timing, one field per edge
        load_all(56'h24_05_15_03_C8_59_59);
        pulse_tick();               // after E1
        rd_reg(3'd0, b); check("R12", 56'(b), 56'h59);
        @(negedge clk);             // after E2
        rd_reg(3'd0, b); check("R12", 56'(b), 56'h00);
        rd_reg(3'd1, b); check("R12", 56'(b), 56'h59);
        @(negedge clk);             // after E3
        rd_reg(3'd1, b); check("R12", 56'(b), 56'h00);
        rd_reg(3'd2, b); check("R12", 56'(b), 56'hC8);
        @(negedge clk);             // after E4
        rd_reg(3'd2, b); check("R12", 56'(b), 56'hC9);

        // R6 and R7: full ripple reaches the year within seven edges
        load_all(56'h99_12_31_06_E3_59_59);
        pulse_tick();
        wait_cycles(6);             // after E7
        read_all(got); check("R12", got, 56'h00_01_01_07_80_00_00);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule